// File: doc/BRIEF.md
# Register Access Violation Monitor

This block sits on the register bus of a cryptographic engine and watches every read and write. The engine reports whether it is processing a block or expanding sub-keys. The monitor uses those two phase inputs and the start mode held in its own mode register to decide whether an access is allowed. An access that is not allowed is suppressed. The monitor then raises a sticky detection flag and keeps a 4-bit code that says what kind of access broke the rules. Only a software reset issued through the control word clears the flag and the code.

The block also owns three registers:
- The mode register. Its first write must carry an unlock value, or the write is refused.
- An interrupt mask. It is changed through separate set and clear words.
- A status word. It combines the engine's data-ready and tag-ready levels with the violation record.

A registered interrupt line is the OR of the masked status bits. Allowed accesses to the engine's key, input, IV and output words are forwarded to the datapath through one-cycle strobes.

Top module: `bus_access_guard`

## Requirements
- R1: After a synchronous active-low reset the mode word, the mask, the violation flag, the violation code and the interrupt are all zero, and the unlock state is cleared.
- R2: A violation stores a code. The codes are:
  - 0: a write to the input words (0x40..0x4C) while processing with start mode 2 (mode bits 9:8).
  - 1: a read of the output words (0x50..0x5C) while processing.
  - 2: a write to the mode word (0x04) while processing.
  - 3: an output-word read during sub-key generation.
  - 4: a mode-word write during sub-key generation.
  - 5: a read of any write-only word, in any phase. The write-only words are control 0x00, key 0x20..0x3C, input 0x40..0x4C and IV 0x60..0x6C.
- R3: The status word at 0x1C shows the detection flag at bit 8 and the code at bits 15:12. Both are sticky. Both are cleared only by writing 1 to bit 8 of the control word at 0x00.
- R4: While the flag is set, later violations leave the stored code unchanged.
- R5: Writing 1s to the set word (0x10) sets those mask bits, and writing 1s to the clear word (0x14) clears them. Writing 0 to a bit has no effect. The mask reads back at 0x18. Only bits 0, 8 and 16 exist.
- R6: The interrupt output is a register. It equals the OR of (status AND mask) over bits 0, 8 and 16, and it follows that value one clock later.
- R7: While locked, a mode write is accepted only when bits 23:20 equal 0xE. A refused write leaves the mode word unchanged and is not a violation.
- R8: Once unlocked, a mode write is accepted whatever bits 23:20 hold. Bits 23:20 always read back as 0.
- R9: A violating access has no other effect. A blocked write changes no register and gives no datapath write strobe. A blocked read returns 0 and gives no datapath read strobe.
- R10: Allowed accesses are forwarded to the datapath:
  - A write to key, input or IV words pulses `dp_wr`.
  - A read of the output words pulses `dp_rd` and returns `dp_rdata`.
  - A control write with bit 0 set pulses `start_pulse`.
- R11: Status bit 0 reflects `data_ready` and status bit 16 reflects `tag_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed 32-bit word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| phase_proc | input | 1 | Engine is processing a block |
| phase_keygen | input | 1 | Engine is generating sub-keys |
| data_ready | input | 1 | Engine data-ready level |
| tag_ready | input | 1 | Engine tag-ready level |
| dp_rdata | input | DATA_W | Output word supplied by the datapath |
| dp_wr | output | 1 | Allowed write to a key, input or IV word |
| dp_rd | output | 1 | Allowed read of an output word |
| start_pulse | output | 1 | Allowed control write with start bit set |
| mode_word | output | DATA_W | Current mode word, unlock field zeroed |
| irq | output | 1 | Registered masked interrupt |

## Verification
A lost or corrupted violation record shows up on the first read of the status word after the offending access. It also shows up one clock later on the interrupt line, if the detection bit is unmasked. A code overwritten by a second violation is visible at the very next status read. This is why the stimulus reads status after each violating access and after each software reset. A wrong unlock or mask state appears on the next read-back of the mode or mask word, so every write to those words is followed at once by a read.

// File: rtl/bag_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the bus access guard.
// Assumes word-aligned byte offsets on an 8-bit or wider address.
package bag_pkg;

    // Word offsets decoded by the guard.
    localparam int unsigned OFS_CTRL  = 32'h00;
    localparam int unsigned OFS_MODE  = 32'h04;
    localparam int unsigned OFS_MSET  = 32'h10;
    localparam int unsigned OFS_MCLR  = 32'h14;
    localparam int unsigned OFS_MASK  = 32'h18;
    localparam int unsigned OFS_STAT  = 32'h1C;
    localparam int unsigned OFS_KEY   = 32'h20;
    localparam int unsigned NUM_KEY   = 8;
    localparam int unsigned OFS_DIN   = 32'h40;
    localparam int unsigned NUM_DIN   = 4;
    localparam int unsigned OFS_DOUT  = 32'h50;
    localparam int unsigned NUM_DOUT  = 4;
    localparam int unsigned OFS_IV    = 32'h60;
    localparam int unsigned NUM_IV    = 4;

    // Field positions.
    localparam int unsigned CTRL_START_BIT = 0;
    localparam int unsigned CTRL_SWRST_BIT = 8;
    localparam int unsigned MODE_SMOD_LO   = 8;
    localparam int unsigned MODE_KEY_LO    = 20;
    localparam logic [3:0]  UNLOCK_VALUE   = 4'hE;
    localparam logic [1:0]  SMOD_DMA_WORD0 = 2'd2;
    localparam int unsigned STAT_DET_BIT   = 8;
    localparam int unsigned STAT_CODE_LO   = 12;

    // Interrupt sources: data ready, violation, tag ready.
    localparam int unsigned NSRC = 3;
    localparam int unsigned SRC_BIT [NSRC] = '{0, 8, 16};

    typedef enum logic [3:0] {
        VC_DIN_WR_PROC   = 4'd0,
        VC_DOUT_RD_PROC  = 4'd1,
        VC_MODE_WR_PROC  = 4'd2,
        VC_DOUT_RD_KGEN  = 4'd3,
        VC_MODE_WR_KGEN  = 4'd4,
        VC_WONLY_RD      = 4'd5
    } vcode_e;

    typedef struct packed {
        logic ctrl;
        logic mode;
        logic mset;
        logic mclr;
        logic mask;
        logic stat;
        logic key;
        logic din;
        logic dout;
        logic iv;
    } region_t;

endpackage

// File: rtl/bag_decode.sv
`timescale 1ns/1ps
// Address decode and access legality check.
// Purely combinational; assumes at most one of read/write per cycle
// (a write takes precedence in classification if both appear).
module bag_decode
    import bag_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              proc,
    input  logic              keygen,
    input  logic [1:0]        smod,
    output region_t           reg_hit,
    output logic              viol,
    output logic [3:0]        vcode
);

    // True when addr selects one of n consecutive words starting at lo.
    function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                    input int unsigned lo,
                                    input int unsigned n);
        return (a[1:0] == 2'b00) &&
               (a >= ADDR_W'(lo)) &&
               (a <= ADDR_W'(lo + 4 * (n - 1)));
    endfunction

    // Region decode.
    always_comb begin
        reg_hit.ctrl = in_win(addr, OFS_CTRL, 1);
        reg_hit.mode = in_win(addr, OFS_MODE, 1);
        reg_hit.mset = in_win(addr, OFS_MSET, 1);
        reg_hit.mclr = in_win(addr, OFS_MCLR, 1);
        reg_hit.mask = in_win(addr, OFS_MASK, 1);
        reg_hit.stat = in_win(addr, OFS_STAT, 1);
        reg_hit.key  = in_win(addr, OFS_KEY,  NUM_KEY);
        reg_hit.din  = in_win(addr, OFS_DIN,  NUM_DIN);
        reg_hit.dout = in_win(addr, OFS_DOUT, NUM_DOUT);
        reg_hit.iv   = in_win(addr, OFS_IV,   NUM_IV);
    end

    logic wonly;
    assign wonly = reg_hit.ctrl | reg_hit.key | reg_hit.din | reg_hit.iv;

    // Classify the access against the current phase.
    always_comb begin
        viol  = 1'b0;
        vcode = VC_WONLY_RD;
        if (wr) begin
            if (proc) begin
                if (reg_hit.din && (smod == SMOD_DMA_WORD0)) begin
                    viol  = 1'b1;
                    vcode = VC_DIN_WR_PROC;
                end else if (reg_hit.mode) begin
                    viol  = 1'b1;
                    vcode = VC_MODE_WR_PROC;
                end
            end else if (keygen && reg_hit.mode) begin
                viol  = 1'b1;
                vcode = VC_MODE_WR_KGEN;
            end
        end else if (rd) begin
            if (reg_hit.dout && proc) begin
                viol  = 1'b1;
                vcode = VC_DOUT_RD_PROC;
            end else if (reg_hit.dout && keygen) begin
                viol  = 1'b1;
                vcode = VC_DOUT_RD_KGEN;
            end else if (wonly) begin
                viol  = 1'b1;
                vcode = VC_WONLY_RD;
            end
        end
    end

endmodule

// File: rtl/bag_viol_rec.sv
`timescale 1ns/1ps
// Sticky violation recorder: keeps the flag and the first code.
// Assumes clr and evt never coincide; clr wins if they do.
module bag_viol_rec #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              evt,
    input  logic [CODE_W-1:0] code_in,
    output logic              det_q,
    output logic [CODE_W-1:0] code_q
);

    // Capture the first violation; hold until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            det_q  <= 1'b0;
            code_q <= '0;
        end else if (evt && !det_q) begin
            det_q  <= 1'b1;
            code_q <= code_in;
        end
    end

endmodule

// File: rtl/bag_irq_ctrl.sv
`timescale 1ns/1ps
// Interrupt mask (set/clear words) and registered interrupt output.
// Only the source bit positions listed in the package carry flops.
module bag_irq_ctrl
    import bag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] mask_word,
    output logic              irq_q
);

    logic [NSRC-1:0] mbit;
    logic [NSRC-1:0] pend;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam int unsigned POS = SRC_BIT[s];

        // One mask bit: set-word 1 sets, clear-word 1 clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mbit[s] <= 1'b0;
            end else if (set_wr && wdata[POS]) begin
                mbit[s] <= 1'b1;
            end else if (clr_wr && wdata[POS]) begin
                mbit[s] <= 1'b0;
            end
        end

        assign pend[s] = mbit[s] & status[POS];
    end

    // Scatter mask bits into their word positions.
    always_comb begin
        mask_word = '0;
        for (int s = 0; s < NSRC; s++) begin
            mask_word[SRC_BIT[s]] = mbit[s];
        end
    end

    // Register the combined masked request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pend;
        end
    end

endmodule

// File: rtl/bag_mode_reg.sv
`timescale 1ns/1ps
// Mode word with one-time unlock on first write.
// wr_ok must already exclude blocked (violating) writes.
module bag_mode_reg
    import bag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic              unlocked_q
);

    localparam logic [DATA_W-1:0] KEY_MASK = DATA_W'(32'hF) << MODE_KEY_LO;

    logic accept;
    assign accept = wr_ok &&
                    (unlocked_q || (wdata[MODE_KEY_LO +: 4] == UNLOCK_VALUE));

    // Store accepted writes with the unlock field dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= '0;
            unlocked_q <= 1'b0;
        end else if (accept) begin
            mode_q     <= wdata & ~KEY_MASK;
            unlocked_q <= 1'b1;
        end
    end

endmodule

// File: rtl/bus_access_guard.sv
`timescale 1ns/1ps
// Bus access guard for a crypto engine register window.
// Blocks phase-illegal accesses, records the first one, owns the
// mode, mask and status words and drives a registered interrupt.
// Assumes single-cycle accesses with at most one strobe active.
module bus_access_guard
    import bag_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              phase_proc,
    input  logic              phase_keygen,
    input  logic              data_ready,
    input  logic              tag_ready,
    input  logic [DATA_W-1:0] dp_rdata,
    output logic              dp_wr,
    output logic              dp_rd,
    output logic              start_pulse,
    output logic [DATA_W-1:0] mode_word,
    output logic              irq
);

    localparam int CODE_W = 4;

    region_t           hit;
    logic              viol;
    logic [CODE_W-1:0] vcode;
    logic              det_q;
    logic [CODE_W-1:0] vcode_q;
    logic              swrst;
    logic [DATA_W-1:0] mode_q;
    logic              unlocked;
    logic [DATA_W-1:0] mask_word;
    logic [DATA_W-1:0] status_word;
    logic              ok_wr;
    logic              ok_rd;

    bag_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .proc    (phase_proc),
        .keygen  (phase_keygen),
        .smod    (mode_q[MODE_SMOD_LO +: 2]),
        .reg_hit (hit),
        .viol    (viol),
        .vcode   (vcode)
    );

    assign ok_wr = bus_wr & ~viol;
    assign ok_rd = bus_rd & ~viol;

    assign swrst       = ok_wr & hit.ctrl & bus_wdata[CTRL_SWRST_BIT];
    assign start_pulse = ok_wr & hit.ctrl & bus_wdata[CTRL_START_BIT];
    assign dp_wr       = ok_wr & (hit.key | hit.din | hit.iv);
    assign dp_rd       = ok_rd & hit.dout;

    bag_viol_rec #(.CODE_W(CODE_W)) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (swrst),
        .evt     (viol),
        .code_in (vcode),
        .det_q   (det_q),
        .code_q  (vcode_q)
    );

    bag_mode_reg #(.DATA_W(DATA_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ok      (ok_wr & hit.mode),
        .wdata      (bus_wdata),
        .mode_q     (mode_q),
        .unlocked_q (unlocked)
    );

    // Assemble the status word from engine levels and the record.
    always_comb begin
        status_word = '0;
        status_word[SRC_BIT[0]] = data_ready;
        status_word[STAT_DET_BIT] = det_q;
        status_word[STAT_CODE_LO +: CODE_W] = vcode_q;
        status_word[SRC_BIT[2]] = tag_ready;
    end

    bag_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wr    (ok_wr & hit.mset),
        .clr_wr    (ok_wr & hit.mclr),
        .wdata     (bus_wdata),
        .status    (status_word),
        .mask_word (mask_word),
        .irq_q     (irq)
    );

    // Read multiplexer; blocked or unmapped reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (ok_rd) begin
            if (hit.mode)      bus_rdata = mode_q;
            else if (hit.mask) bus_rdata = mask_word;
            else if (hit.stat) bus_rdata = status_word;
            else if (hit.dout) bus_rdata = dp_rdata;
        end
    end

    assign mode_word = mode_q;

endmodule

// File: rtl/bag_chk.sv
`timescale 1ns/1ps
// Property checker for bus_access_guard, attached by bind below.
module bag_chk
    import bag_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              dp_wr,
    input logic              dp_rd,
    input logic              irq,
    input logic              viol,
    input logic              swrst,
    input logic              det_q,
    input logic [3:0]        vcode_q,
    input logic              unlocked,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] mask_word,
    input logic [DATA_W-1:0] status_word
);

    logic mode_acc;
    assign mode_acc = bus_addr == ADDR_W'(OFS_MODE);

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        det_q && !swrst |=> det_q);

    a_r3_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> !det_q && (vcode_q == 4'd0));

    a_r4_first_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        det_q && !swrst |=> $stable(vcode_q));

    a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(|(status_word & mask_word)));

    a_r7_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked && bus_wr && mode_acc &&
        (bus_wdata[MODE_KEY_LO +: 4] != UNLOCK_VALUE) |=> $stable(mode_q));

    a_r8_key_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && mode_acc |-> bus_rdata[MODE_KEY_LO +: 4] == 4'd0);

    a_r9_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && viol |-> bus_rdata == '0);

    a_r9_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> !dp_wr && !dp_rd);

endmodule

bind bus_access_guard bag_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .dp_wr       (dp_wr),
    .dp_rd       (dp_rd),
    .irq         (irq),
    .viol        (viol),
    .swrst       (swrst),
    .det_q       (det_q),
    .vcode_q     (vcode_q),
    .unlocked    (unlocked),
    .mode_q      (mode_q),
    .mask_word   (mask_word),
    .status_word (status_word)
);

// File: tb/sim_bus_access_guard.sv
`timescale 1ns/1ps
module sim_bus_access_guard;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [1:0] OP_W = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;
    localparam logic [31:0] DPV = 32'hA5A5_A5A5;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] wd;
        logic        pr;
        logic        sk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Stimulus table; reads carry the expected bus_rdata.
    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{OP_R, 8'h04, 32'h0,         1'b0, 1'b0, 32'h0,         4'd1},  // R1 mode zero
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0,         4'd1},  // R1 status zero
        '{OP_W, 8'h04, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd7},  // R7 no unlock
        '{OP_R, 8'h04, 32'h0,         1'b0, 1'b0, 32'h0,         4'd7},
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0,         4'd7},  // R7 not a violation
        '{OP_W, 8'h04, 32'h00E0_0201, 1'b0, 1'b0, 32'h0,         4'd8},
        '{OP_R, 8'h04, 32'h0,         1'b0, 1'b0, 32'h0000_0201, 4'd8},  // R8 field reads 0
        '{OP_W, 8'h04, 32'h0050_0203, 1'b0, 1'b0, 32'h0,         4'd8},
        '{OP_R, 8'h04, 32'h0,         1'b0, 1'b0, 32'h0000_0203, 4'd8},  // R8 any value later
        '{OP_W, 8'h10, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd5},
        '{OP_R, 8'h18, 32'h0,         1'b0, 1'b0, 32'h0000_0100, 4'd5},
        '{OP_W, 8'h10, 32'h0,         1'b0, 1'b0, 32'h0,         4'd5},
        '{OP_R, 8'h18, 32'h0,         1'b0, 1'b0, 32'h0000_0100, 4'd5},  // R5 zero no effect
        '{OP_R, 8'h50, 32'h0,         1'b1, 1'b0, 32'h0,         4'd9},  // R9 blocked read
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0000_1100, 4'd2},  // R2 code 1
        '{OP_W, 8'h04, 32'h0,         1'b1, 1'b0, 32'h0,         4'd9},
        '{OP_R, 8'h04, 32'h0,         1'b0, 1'b0, 32'h0000_0203, 4'd9},  // R9 mode unchanged
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0000_1100, 4'd4},  // R4 first kept
        '{OP_W, 8'h00, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd3},
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0,         4'd3},  // R3 cleared
        '{OP_W, 8'h04, 32'h0,         1'b0, 1'b1, 32'h0,         4'd2},
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0000_4100, 4'd2},  // R2 code 4
        '{OP_W, 8'h00, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd3},
        '{OP_R, 8'h24, 32'h0,         1'b0, 1'b0, 32'h0,         4'd9},
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0000_5100, 4'd2},  // R2 code 5
        '{OP_W, 8'h00, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd3},
        '{OP_W, 8'h40, 32'h1234_5678, 1'b1, 1'b0, 32'h0,         4'd2},
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0000_0100, 4'd2},  // R2 code 0
        '{OP_W, 8'h00, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd3},
        '{OP_R, 8'h50, 32'h0,         1'b0, 1'b1, 32'h0,         4'd9},
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0000_3100, 4'd2},  // R2 code 3
        '{OP_W, 8'h00, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd3},
        '{OP_W, 8'h04, 32'h0000_0200, 1'b1, 1'b0, 32'h0,         4'd2},
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0000_2100, 4'd2},  // R2 code 2
        '{OP_W, 8'h00, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd3},
        '{OP_R, 8'h50, 32'h0,         1'b0, 1'b0, DPV,           4'd10}, // R10 passthrough
        '{OP_R, 8'h1C, 32'h0,         1'b0, 1'b0, 32'h0,         4'd10},
        '{OP_W, 8'h14, 32'h0000_0100, 1'b0, 1'b0, 32'h0,         4'd5},
        '{OP_R, 8'h18, 32'h0,         1'b0, 1'b0, 32'h0,         4'd5}   // R5 clear word
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          phase_proc = 1'b0;
    logic          phase_keygen = 1'b0;
    logic          data_ready = 1'b0;
    logic          tag_ready = 1'b0;
    logic [DW-1:0] dp_rdata = DPV;
    logic          dp_wr;
    logic          dp_rd;
    logic          start_pulse;
    logic [DW-1:0] mode_word;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_access_guard #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; caller samples 5 ns later.
    task automatic drive(input logic [1:0] op, input logic [7:0] a,
                         input logic [31:0] wd, input logic pr, input logic sk);
        @(negedge clk);
        bus_wr = (op == OP_W);
        bus_rd = (op == OP_R);
        bus_addr = a;
        bus_wdata = wd;
        phase_proc = pr;
        phase_keygen = sk;
        #5;
    endtask

    task automatic idle();
        drive(2'd0, 8'h0, 32'h0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].pr, VEC[i].sk);
            if (VEC[i].op == OP_R)
                check($sformatf("R%0d vec%0d", VEC[i].req, i), bus_rdata, VEC[i].exp);
        end

        // R10 allowed input write is forwarded.
        drive(OP_W, 8'h40, 32'h1, 1'b0, 1'b0);
        check("R10 dp_wr", {31'd0, dp_wr}, 32'd1);
        // R9 blocked input write not forwarded.
        drive(OP_W, 8'h44, 32'h1, 1'b1, 1'b0);
        check("R9 dp_wr blocked", {31'd0, dp_wr}, 32'd0);
        drive(OP_W, 8'h00, 32'h0000_0101, 1'b0, 1'b0);
        check("R10 start_pulse", {31'd0, start_pulse}, 32'd1);
        drive(OP_R, 8'h1C, 32'h0, 1'b0, 1'b0);
        check("R3 cleared by swrst", bus_rdata, 32'h0);

        // R6 interrupt from data ready, one clock after the level.
        drive(OP_W, 8'h10, 32'h1, 1'b0, 1'b0);
        idle();
        data_ready = 1'b1;
        #1;
        check("R6 irq not yet", {31'd0, irq}, 32'd0);
        idle();
        check("R6 irq set", {31'd0, irq}, 32'd1);
        data_ready = 1'b0;
        idle();
        check("R6 irq drop", {31'd0, irq}, 32'd0);

        // R11 tag ready visible; masked off so irq stays low (R6).
        tag_ready = 1'b1;
        drive(OP_R, 8'h1C, 32'h0, 1'b0, 1'b0);
        check("R11 status", bus_rdata, 32'h0001_0000);
        idle();
        idle();
        check("R6 masked tag", {31'd0, irq}, 32'd0);
        tag_ready = 1'b0;

        // R1 hardware reset returns all state to zero, relocks.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(OP_R, 8'h18, 32'h0, 1'b0, 1'b0);
        check("R1 mask after reset", bus_rdata, 32'h0);
        check("R1 mode port", mode_word, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        drive(OP_W, 8'h04, 32'h0000_0300, 1'b0, 1'b0);
        drive(OP_R, 8'h04, 32'h0, 1'b0, 1'b0);
        check("R7 relocked", bus_rdata, 32'h0);
        idle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule